// File: doc/BRIEF.md
# CSI-2 Packet Header Error Classifier

This block sits behind the lane merger of a camera serial receiver. It takes one byte per cycle, with markers for the first and last byte of each packet, and parses each packet. It decodes the 32-bit header and repairs or rejects it using the header's error-correcting code. On long packets it checks the 16-bit payload checksum. For every header it reports one decision: forward the packet downstream, or drop it.

Each class of fault has one fixed outcome. A single flipped header bit is corrected and the packet is still forwarded. Two flipped bits make the packet unusable, so it is dropped. A packet whose start-of-transmission could not be synchronised is dropped without further analysis. A checksum mismatch and an unknown data type are only reported. Every reported fault except the double-bit header fault is a one-cycle pulse on the line of the packet's virtual channel. A separate status block collects these pulses.

Top module: `csi_hdr_classifier`

## Requirements
- R1: After reset, and on every cycle where no header or checksum result is due, `hdr_valid` and all error pulse outputs are 0.
- R2: A header is taken from four bytes. Byte 0 holds the virtual channel in bits 7:6 and the data type in bits 5:0. Bytes 1 and 2 hold the word count, low byte first. Byte 3 holds the 6-bit ECC in bits 5:0. One cycle after byte 3 is accepted, `hdr_valid` pulses for one cycle with the fields and `hdr_drop`=0 when the header is clean. Two `hdr_valid` pulses are never adjacent.
- R3: An ECC syndrome that points at a single header bit, or at a single ECC bit, is corrected. The packet is forwarded with the corrected fields, and `err_ecc_corr[vc]` pulses with `hdr_valid`, where vc is the corrected channel.
- R4: Any other nonzero syndrome is a double error. `hdr_drop`=1 and `err_ecc_double` pulses with `hdr_valid`, and no per-channel pulse is raised.
- R5: A packet whose first byte arrives with `in_sot_nosync`=1 is reported with `hdr_drop`=1, and no error pulse is raised for it.
- R6: On a forwarded long packet, the checksum is CRC-16 with polynomial x^16+x^12+x^5+1, seed 0xFFFF, no final inversion, bits taken LSB first. It covers the word-count payload bytes and is received low byte first right after them. One cycle after the second checksum byte, `err_crc[vc]` pulses when the checksum mismatches and stays 0 when it matches.
- R7: Only these data types are recognised: 0x00-0x03, 0x08-0x12, 0x18-0x24, 0x28-0x2D and 0x30-0x37. Any other data type on a forwarded header pulses `err_id[vc]` with `hdr_valid`, and the packet is still forwarded.
- R8: Data types below 0x10 are short packets with no payload or checksum. The next packet's header is parsed right after the short packet.
- R9: A byte with `in_eop` ends the packet: an unfinished checksum is abandoned without a pulse. A byte with `in_sop` always restarts header parsing at byte 0.
- R10: The payload and checksum of a dropped long packet are skipped up to `in_eop` and produce no checksum pulse.
- R11: A long packet with word count 0 carries only the two checksum bytes, and its checksum is the seed value 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Byte present this cycle |
| in_byte | input | 8 | Stream byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_sot_nosync | input | 1 | Start of transmission not synchronised, given with the first byte |
| hdr_valid | output | 1 | One-cycle header decision strobe |
| hdr_drop | output | 1 | Packet is not forwarded (qualified by hdr_valid) |
| hdr_vc | output | 2 | Corrected virtual channel |
| hdr_dt | output | 6 | Corrected data type |
| hdr_wc | output | 16 | Corrected word count |
| err_ecc_corr | output | 4 | Per-channel corrected-header pulse |
| err_ecc_double | output | 1 | Uncorrectable header pulse |
| err_crc | output | 4 | Per-channel payload checksum mismatch pulse |
| err_id | output | 4 | Per-channel unrecognised data type pulse |

## Verification
The bench flips each of the 30 header and ECC bits in turn. This shows that every syndrome column is mapped to the right bit, and that parity-bit errors are kept apart from data-bit errors. Pairs of flips at several spans, including on long packets, separate a double error from a miscorrection and show that the dropped payload is skipped. Long packets with good and bad checksums, zero word count, inter-byte gaps, early end markers and start markers in mid-payload show that the checksum window lines up exactly with the word count. Unsynchronised starts and unknown data types, alone and together with a corrected bit, confirm the disposition chosen for each fault class.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;

  localparam int BYTE_BITS = 8;
  localparam int VC_BITS   = 2;
  localparam int DT_BITS   = 6;
  localparam int WC_BITS   = 16;
  localparam int HDR_BITS  = VC_BITS + DT_BITS + WC_BITS;
  localparam int SYN_BITS  = 6;
  localparam int CRC_BITS  = 16;
  localparam int NUM_VC    = 1 << VC_BITS;

  localparam logic [CRC_BITS-1:0] CRC_SEED      = 16'hFFFF;
  localparam logic [CRC_BITS-1:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [DT_BITS-1:0]  LONG_DT_MIN   = 6'h10;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_FATAL = 2'd2
  } ecc_res_e;

  typedef enum logic [2:0] {
    ST_HDR  = 3'd0,
    ST_PAY  = 3'd1,
    ST_CK0  = 3'd2,
    ST_CK1  = 3'd3,
    ST_SKIP = 3'd4
  } parse_st_e;

  // Syndrome produced by a flip of header bit idx.
  function automatic logic [SYN_BITS-1:0] ecc_col(input int unsigned idx);
    logic [SYN_BITS-1:0] c;
    case (idx)
      0:  c = 6'h07;  1:  c = 6'h0B;  2:  c = 6'h0D;  3:  c = 6'h0E;
      4:  c = 6'h13;  5:  c = 6'h15;  6:  c = 6'h16;  7:  c = 6'h19;
      8:  c = 6'h1A;  9:  c = 6'h1C;  10: c = 6'h23;  11: c = 6'h25;
      12: c = 6'h26;  13: c = 6'h29;  14: c = 6'h2A;  15: c = 6'h2C;
      16: c = 6'h31;  17: c = 6'h32;  18: c = 6'h34;  19: c = 6'h38;
      20: c = 6'h1F;  21: c = 6'h2F;  22: c = 6'h37;  23: c = 6'h3B;
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [SYN_BITS-1:0] ecc_calc(input logic [HDR_BITS-1:0] d);
    logic [SYN_BITS-1:0] p;
    p = '0;
    for (int i = 0; i < HDR_BITS; i++) begin
      if (d[i]) p = p ^ ecc_col(i);
    end
    return p;
  endfunction

  function automatic logic [CRC_BITS-1:0] crc_byte(input logic [CRC_BITS-1:0] c,
                                                   input logic [BYTE_BITS-1:0] b);
    logic [CRC_BITS-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_BITS; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic dt_known(input logic [DT_BITS-1:0] dt);
    return (dt <= 6'h03)
        || ((dt >= 6'h08) && (dt <= 6'h12))
        || ((dt >= 6'h18) && (dt <= 6'h24))
        || ((dt >= 6'h28) && (dt <= 6'h2D))
        || ((dt >= 6'h30) && (dt <= 6'h37));
  endfunction

endpackage

// File: rtl/hdr_ecc_dec.sv
module hdr_ecc_dec
  import pkt_cls_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr_in,
  input  logic [SYN_BITS-1:0] chk_in,
  output logic [HDR_BITS-1:0] hdr_out,
  output ecc_res_e            res
);

  logic [SYN_BITS-1:0] syn;
  logic [HDR_BITS-1:0] hit;

  assign syn = ecc_calc(hdr_in) ^ chk_in;

  for (genvar g = 0; g < HDR_BITS; g++) begin : g_col
    assign hit[g] = (syn == ecc_col(g));
  end

  assign hdr_out = hdr_in ^ hit;

  always_comb begin
    if (syn == '0)                                       res = ECC_CLEAN;
    else if ((|hit) || ((syn & (syn - 1'b1)) == '0))     res = ECC_FIXED;
    else                                                 res = ECC_FATAL;
  end

endmodule

// File: rtl/crc16_acc.sv
module crc16_acc
  import pkt_cls_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [BYTE_BITS-1:0] data,
  output logic [CRC_BITS-1:0]  crc
);

  logic [CRC_BITS-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = CRC_SEED;
    else if (en) crc_d = crc_byte(crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/csi_hdr_classifier.sv
module csi_hdr_classifier
  import pkt_cls_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [BYTE_BITS-1:0] in_byte,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic                 in_sot_nosync,
  output logic                 hdr_valid,
  output logic                 hdr_drop,
  output logic [VC_BITS-1:0]   hdr_vc,
  output logic [DT_BITS-1:0]   hdr_dt,
  output logic [WC_BITS-1:0]   hdr_wc,
  output logic [NUM_VC-1:0]    err_ecc_corr,
  output logic                 err_ecc_double,
  output logic [NUM_VC-1:0]    err_crc,
  output logic [NUM_VC-1:0]    err_id
);

  localparam int IDX_BITS = 2;

  // parser state
  parse_st_e             st_q, st_d;
  logic [IDX_BITS-1:0]   idx_q, idx_d;
  logic [HDR_BITS-1:0]   hbuf_q, hbuf_d;
  logic                  sot_q, sot_d;
  logic [WC_BITS-1:0]    rem_q, rem_d;
  logic [BYTE_BITS-1:0]  cklo_q, cklo_d;

  // result registers
  logic                  hv_q, hv_d, drop_q, drop_d, dbl_q, dbl_d;
  logic                  fld_en;
  logic [VC_BITS-1:0]    vc_q;
  logic [DT_BITS-1:0]    dt_q;
  logic [WC_BITS-1:0]    wc_q;
  logic [NUM_VC-1:0]     corr_q, corr_d, crce_q, crce_d, ide_q, ide_d;

  // checksum accumulator
  logic                  crc_clr, crc_en;
  logic [CRC_BITS-1:0]   crc_val;

  // header decode
  logic                  hdr_phase;
  logic [IDX_BITS-1:0]   pos;
  logic [HDR_BITS-1:0]   fixed_hdr;
  ecc_res_e              ecc_res;
  logic [VC_BITS-1:0]    fx_vc;
  logic [DT_BITS-1:0]    fx_dt;
  logic [WC_BITS-1:0]    fx_wc;

  assign hdr_phase = in_sop || (st_q == ST_HDR);
  assign pos       = in_sop ? '0 : idx_q;

  hdr_ecc_dec u_ecc (
    .hdr_in  (hbuf_q),
    .chk_in  (in_byte[SYN_BITS-1:0]),
    .hdr_out (fixed_hdr),
    .res     (ecc_res)
  );

  assign fx_dt = fixed_hdr[DT_BITS-1:0];
  assign fx_vc = fixed_hdr[DT_BITS +: VC_BITS];
  assign fx_wc = fixed_hdr[DT_BITS+VC_BITS +: WC_BITS];

  crc16_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .data  (in_byte),
    .crc   (crc_val)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    hbuf_d  = hbuf_q;
    sot_d   = sot_q;
    rem_d   = rem_q;
    cklo_d  = cklo_q;
    hv_d    = 1'b0;
    drop_d  = 1'b0;
    dbl_d   = 1'b0;
    fld_en  = 1'b0;
    corr_d  = '0;
    crce_d  = '0;
    ide_d   = '0;
    crc_clr = 1'b0;
    crc_en  = 1'b0;

    if (in_valid) begin
      if (hdr_phase) begin
        st_d  = ST_HDR;
        idx_d = pos + 1'b1;
        case (pos)
          2'd0: begin
            hbuf_d[BYTE_BITS-1:0] = in_byte;
            sot_d = in_sot_nosync;
          end
          2'd1: hbuf_d[BYTE_BITS +: BYTE_BITS]   = in_byte;
          2'd2: hbuf_d[2*BYTE_BITS +: BYTE_BITS] = in_byte;
          default: begin
            hv_d   = 1'b1;
            fld_en = 1'b1;
            idx_d  = '0;
            if (sot_q) begin
              drop_d = 1'b1;
            end else if (ecc_res == ECC_FATAL) begin
              drop_d = 1'b1;
              dbl_d  = 1'b1;
            end else begin
              if (ecc_res == ECC_FIXED) corr_d[fx_vc] = 1'b1;
              if (!dt_known(fx_dt))     ide_d[fx_vc]  = 1'b1;
            end
            if (drop_d || (fx_dt < LONG_DT_MIN)) begin
              st_d = ST_SKIP;
            end else if (fx_wc == '0) begin
              st_d    = ST_CK0;
              crc_clr = 1'b1;
            end else begin
              st_d    = ST_PAY;
              rem_d   = fx_wc;
              crc_clr = 1'b1;
            end
          end
        endcase
      end else begin
        case (st_q)
          ST_PAY: begin
            crc_en = 1'b1;
            rem_d  = rem_q - 1'b1;
            if (rem_q == 1) st_d = ST_CK0;
          end
          ST_CK0: begin
            cklo_d = in_byte;
            st_d   = ST_CK1;
          end
          ST_CK1: begin
            if ({in_byte, cklo_q} != crc_val) crce_d[vc_q] = 1'b1;
            st_d = ST_SKIP;
          end
          default: st_d = ST_SKIP;
        endcase
      end
      if (in_eop) begin
        st_d  = ST_HDR;
        idx_d = '0;
      end
    end
  end

  // parser registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      idx_q  <= '0;
      hbuf_q <= '0;
      sot_q  <= 1'b0;
      rem_q  <= '0;
      cklo_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      hbuf_q <= hbuf_d;
      sot_q  <= sot_d;
      rem_q  <= rem_d;
      cklo_q <= cklo_d;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q   <= 1'b0;
      drop_q <= 1'b0;
      dbl_q  <= 1'b0;
      corr_q <= '0;
      crce_q <= '0;
      ide_q  <= '0;
      vc_q   <= '0;
      dt_q   <= '0;
      wc_q   <= '0;
    end else begin
      hv_q   <= hv_d;
      drop_q <= drop_d;
      dbl_q  <= dbl_d;
      corr_q <= corr_d;
      crce_q <= crce_d;
      ide_q  <= ide_d;
      if (fld_en) begin
        vc_q <= fx_vc;
        dt_q <= fx_dt;
        wc_q <= fx_wc;
      end
    end
  end

  assign hdr_valid      = hv_q;
  assign hdr_drop       = drop_q;
  assign hdr_vc         = vc_q;
  assign hdr_dt         = dt_q;
  assign hdr_wc         = wc_q;
  assign err_ecc_corr   = corr_q;
  assign err_ecc_double = dbl_q;
  assign err_crc        = crce_q;
  assign err_id         = ide_q;

  // R2: a header takes four bytes, so decisions never come back to back
  a_r2_hdr_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  // R3: a correction names exactly the delivered header's channel
  a_r3_fix_delivers: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_ecc_corr) |-> hdr_valid && !hdr_drop && ($countones(err_ecc_corr) == 1)
                        && err_ecc_corr[hdr_vc]);

  // R4: a double error always comes with a drop
  a_r4_double_drops: assert property (@(posedge clk) disable iff (!rst_n)
    err_ecc_double |-> hdr_valid && hdr_drop);

  // R5 / R4: a dropped header raises no per-channel header pulse
  a_r5_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_drop) |-> (err_ecc_corr == '0) && (err_id == '0));

  // R6: checksum result follows the second checksum byte, never a header
  a_r6_crc_after_ck1: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_crc) |-> $onehot0(err_crc) && !hdr_valid && ($past(st_q) == ST_CK1));

  // R7: type errors only on forwarded headers, on their channel
  a_r7_id_on_header: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_id) |-> hdr_valid && !hdr_drop && $onehot0(err_id) && err_id[hdr_vc]);

endmodule

// File: tb/csi_hdr_classifier_tb_top.sv
module csi_hdr_classifier_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop, in_sot;
  logic [7:0]  in_byte;
  logic        hdr_valid, hdr_drop, err_ecc_double;
  logic [1:0]  hdr_vc;
  logic [5:0]  hdr_dt;
  logic [15:0] hdr_wc;
  logic [3:0]  err_ecc_corr, err_crc, err_id;

  always #10 clk = ~clk;  // 50 MHz

  csi_hdr_classifier dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_byte        (in_byte),
    .in_sop         (in_sop),
    .in_eop         (in_eop),
    .in_sot_nosync  (in_sot),
    .hdr_valid      (hdr_valid),
    .hdr_drop       (hdr_drop),
    .hdr_vc         (hdr_vc),
    .hdr_dt         (hdr_dt),
    .hdr_wc         (hdr_wc),
    .err_ecc_corr   (err_ecc_corr),
    .err_ecc_double (err_ecc_double),
    .err_crc        (err_crc),
    .err_id         (err_id)
  );

  typedef struct {
    bit        v;
    bit        d;
    bit [1:0]  vc;
    bit [5:0]  dt;
    bit [15:0] wc;
    bit [3:0]  corr;
    bit        dbl;
    bit [3:0]  crc;
    bit [3:0]  id;
    string     tag;
  } exp_t;

  exp_t expm[int];
  int   dn = 0;
  int   mn = 0;
  int   checks = 0;
  int   fails = 0;
  bit   running = 0;
  bit   done = 0;

  function automatic exp_t quiet(input string t);
    exp_t e;
    e.v = 0; e.d = 0; e.vc = 0; e.dt = 0; e.wc = 0;
    e.corr = 0; e.dbl = 0; e.crc = 0; e.id = 0; e.tag = t;
    return e;
  endfunction

  function automatic bit [5:0] ref_ecc(input bit [23:0] d);
    bit [5:0] p;
    p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
    p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
    p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
    p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
    p[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
    p[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
    return p;
  endfunction

  function automatic bit [15:0] ref_crc(input bit [15:0] c, input bit [7:0] b);
    bit [15:0] r;
    bit        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  function automatic bit ref_known(input bit [5:0] dt);
    int v;
    v = int'(dt);
    return (v < 4) || (v >= 8 && v < 19) || (v >= 24 && v < 37)
        || (v >= 40 && v < 46) || (v >= 48 && v < 56);
  endfunction

  function automatic bit [38:0] pack(input exp_t m, input bit fld);
    return {m.v, m.d, fld ? m.vc : 2'b0, fld ? m.dt : 6'b0, fld ? m.wc : 16'b0,
            m.corr, m.dbl, m.crc, m.id};
  endfunction

  function automatic exp_t observe();
    exp_t a;
    a = quiet("");
    a.v = hdr_valid; a.d = hdr_drop; a.vc = hdr_vc; a.dt = hdr_dt; a.wc = hdr_wc;
    a.corr = err_ecc_corr; a.dbl = err_ecc_double; a.crc = err_crc; a.id = err_id;
    return a;
  endfunction

  task automatic compare(input exp_t e);
    exp_t a;
    bit   fld;
    a   = observe();
    fld = e.v && !e.d;
    checks++;
    if (pack(a, fld) !== pack(e, fld)) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h (v,d,vc,dt,wc,corr,dbl,crc,id)",
               e.tag, mn, pack(a, fld), pack(e, fld));
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin : mon
    exp_t e;
    mn = mn + 1;
    if (running) begin
      if (expm.exists(mn)) begin
        e = expm[mn];
        expm.delete(mn);
      end else begin
        e = quiet("R1");
      end
      compare(e);
    end
  end

  task automatic tick();
    @(negedge clk);
    dn = dn + 1;
  endtask

  task automatic send_byte(input bit [7:0] b, input bit sop, input bit eop,
                           input bit sot, input int gap);
    in_valid = 1'b1; in_byte = b; in_sop = sop; in_eop = eop; in_sot = sot;
    tick();
    in_valid = 1'b0; in_byte = 8'h00; in_sop = 1'b0; in_eop = 1'b0; in_sot = 1'b0;
    repeat (gap) tick();
  endtask

  // cut < 0: full packet; otherwise only cut payload bytes (cut_eop marks the last)
  task automatic send_pkt(input bit [1:0] vc, input bit [5:0] dt, input bit [15:0] wc,
                          input bit [29:0] flips, input bit sot, input bit bad_crc,
                          input int cut, input bit cut_eop, input int gap,
                          input string tag);
    bit [23:0] h;
    bit [29:0] w;
    bit        longp;
    bit        deliver;
    bit [15:0] c;
    bit [7:0]  b;
    int        n;
    exp_t      e;
    exp_t      e2;
    h = {wc, vc, dt};
    w = {ref_ecc(h), h} ^ flips;
    longp = (dt >= 6'h10);
    e = quiet(tag);
    e.v = 1;
    if (sot) begin
      e.d = 1;
    end else if ($countones(flips) >= 2) begin
      e.d = 1; e.dbl = 1;
    end else begin
      e.vc = vc; e.dt = dt; e.wc = wc;
      if ($countones(flips) == 1) e.corr[vc] = 1'b1;
      if (!ref_known(dt))         e.id[vc]   = 1'b1;
    end
    deliver = !e.d;
    send_byte(w[7:0],   1'b1, 1'b0, sot, gap);
    send_byte(w[15:8],  1'b0, 1'b0, 1'b0, gap);
    send_byte(w[23:16], 1'b0, 1'b0, 1'b0, gap);
    expm[dn + 1] = e;
    send_byte({2'b00, w[29:24]}, 1'b0, !longp, 1'b0, gap);
    if (longp) begin
      c = 16'hFFFF;
      n = (cut >= 0) ? cut : int'(wc);
      for (int i = 0; i < n; i++) begin
        b = 8'(i * 37 + int'(wc) + 5);
        c = ref_crc(c, b);
        if (cut >= 0 && i == n - 1) expm[dn + 1] = quiet("R9");
        send_byte(b, 1'b0, (cut >= 0) && cut_eop && (i == n - 1), 1'b0, gap);
      end
      if (cut < 0) begin
        if (bad_crc) c = c ^ 16'h0100;
        send_byte(c[7:0], 1'b0, 1'b0, 1'b0, gap);
        e2 = quiet(deliver ? "R6" : "R10");
        if (deliver && bad_crc) e2.crc[vc] = 1'b1;
        expm[dn + 1] = e2;
        send_byte(c[15:8], 1'b0, 1'b1, 1'b0, gap);
      end
    end
  endtask

  // watchdog
  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_byte = 8'h00; in_sop = 1'b0; in_eop = 1'b0; in_sot = 1'b0;
    repeat (3) tick();
    compare(quiet("R1"));  // reset state
    rst_n = 1'b1;
    running = 1'b1;
    repeat (3) tick();

    // R2 / R8: clean short packets back to back
    send_pkt(2'd0, 6'h00, 16'h1234, 30'h0, 0, 0, -1, 0, 0, "R2");
    send_pkt(2'd1, 6'h02, 16'h00A5, 30'h0, 0, 0, -1, 0, 0, "R8");
    send_pkt(2'd3, 6'h0B, 16'hBEEF, 30'h0, 0, 0, -1, 0, 1, "R8");
    // R2 / R6: clean long packet, good checksum
    send_pkt(2'd2, 6'h2A, 16'd5, 30'h0, 0, 0, -1, 0, 0, "R2");
    // R6: bad checksum, with gaps between bytes
    send_pkt(2'd1, 6'h1E, 16'd3, 30'h0, 0, 1, -1, 0, 1, "R6");
    send_pkt(2'd3, 6'h2B, 16'd4, 30'h0, 0, 1, -1, 0, 2, "R6");
    // R3: every single flipped bit, header and ECC
    for (int k = 0; k < 30; k++)
      send_pkt(2'd3, 6'h01, 16'(k * 977 + 3), 30'h1 << k, 0, 0, -1, 0, 0, "R3");
    // R3: corrected long packet, checksum still checked
    send_pkt(2'd2, 6'h24, 16'd3, 30'h1 << 7, 0, 1, -1, 0, 0, "R3");
    // R4 / R10: double errors on short and long packets
    for (int k = 0; k < 29; k += 4)
      send_pkt(2'd1, 6'h03, 16'h0F0F, 30'h3 << k, 0, 0, -1, 0, 0, "R4");
    send_pkt(2'd0, 6'h12, 16'd4, 30'h21 << 3, 0, 1, -1, 0, 0, "R4");
    send_pkt(2'd2, 6'h2C, 16'd6, 30'h3 << 24, 0, 1, -1, 0, 0, "R10");
    // R5: unsynchronised start, short and long (with bad checksum)
    send_pkt(2'd2, 6'h01, 16'h0007, 30'h0, 1, 0, -1, 0, 0, "R5");
    send_pkt(2'd3, 6'h2B, 16'd6, 30'h0, 1, 1, -1, 0, 0, "R5");
    // R7: unknown types, short, long, and with a corrected bit
    send_pkt(2'd0, 6'h05, 16'h0001, 30'h0, 0, 0, -1, 0, 0, "R7");
    send_pkt(2'd3, 6'h3F, 16'd2, 30'h0, 0, 0, -1, 0, 0, "R7");
    send_pkt(2'd1, 6'h3A, 16'd1, 30'h1 << 9, 0, 1, -1, 0, 0, "R7");
    // R11: zero word count, good and bad checksum
    send_pkt(2'd2, 6'h2C, 16'd0, 30'h0, 0, 0, -1, 0, 0, "R11");
    send_pkt(2'd2, 6'h2C, 16'd0, 30'h0, 0, 1, -1, 0, 0, "R11");
    // R9: early end marker, then a clean packet
    send_pkt(2'd1, 6'h24, 16'd8, 30'h0, 0, 0, 3, 1, 0, "R9");
    send_pkt(2'd1, 6'h10, 16'd2, 30'h0, 0, 1, -1, 0, 0, "R9");
    // R9: start marker in mid-payload restarts header parsing
    send_pkt(2'd0, 6'h2A, 16'd8, 30'h0, 0, 0, 2, 0, 0, "R9");
    send_pkt(2'd0, 6'h1E, 16'd2, 30'h0, 0, 1, -1, 0, 0, "R9");

    repeat (5) tick();
    running = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule